// File: doc/BRIEF.md
# Channel Output Supervisor and Fault Latch

This block supervises one output channel of a switching regulator. It takes digitised comparator flags for the channel output and turns them into four control results. The flags say whether the output is above the over-voltage level, below the under-voltage level, or inside the regulation window. The results are a power-good indication, a request to force the low-side switch on, a run enable for the modulator, and a one-cycle request to restart soft-start.

Each output-level flag first passes through a saturating-counter noise filter, so a short comparator glitch has no effect. Over-voltage works as a self-releasing soft crowbar. Under-voltage is armed only once soft-start has finished, and it latches the channel off. An over-current fault input latches the channel off in the same way. A latched fault stays until enable is cycled low or the supply lockout flag is raised. An over-temperature flag parks the channel until a cool-down flag arrives, and the channel then resumes through a fresh soft-start.

Top module: `chan_supervisor`

## Requirements
- R1: `pwr_good_o` is 1 only while `run_o` is 1, `ss_done_i` is 1 and the filtered window flag is 1. Otherwise it is 0.
- R2: `crowbar_o` follows the filtered over-voltage flag and drops as soon as that flag clears. It does not latch, and it does not stop `run_o`.
- R3: When the filtered under-voltage flag is 1 while `ss_done_i` is 1 and the channel is running, `run_o` goes to 0 on the next clock edge and stays 0 after the flag clears. While `ss_done_i` is 0, the under-voltage flag is ignored.
- R4: Each raw flag (`over_i`, `under_i`, `in_win_i`) changes its filtered value only after it has differed from that value for FILT_LEN consecutive clock edges. A shorter excursion has no effect.
- R5: `ocp_fault_i` high while running latches the channel off, in the same way as under-voltage.
- R6: `temp_hot_i` high stops the channel (`run_o`=0, `pwr_good_o`=0, `crowbar_o`=0). The channel resumes only when `temp_cool_i` is 1 and `temp_hot_i` is 0, and it then issues a restart pulse.
- R7: The channel starts running on the first clock edge at which `en_i`=1 and `uvlo_i`=0. `ss_restart_o` is 1 for exactly the first cycle of every entry into running.
- R8: While `en_i`=0 or `uvlo_i`=1, `run_o`, `pwr_good_o` and `crowbar_o` are 0 in that same cycle.
- R9: A latched fault is cleared by driving `en_i` low for one cycle or by raising `uvlo_i` for one cycle. The channel then restarts with a restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| uvlo_i | input | 1 | 1 while the supply is below its lockout level |
| over_i | input | 1 | Raw flag: output above 120% of set point |
| under_i | input | 1 | Raw flag: output below 75% of set point |
| in_win_i | input | 1 | Raw flag: output inside ±10% of set point |
| ss_done_i | input | 1 | Soft-start has completed |
| temp_hot_i | input | 1 | Die over-temperature flag |
| temp_cool_i | input | 1 | Die has cooled below the restart level |
| ocp_fault_i | input | 1 | Latched over-current fault from the current-limit logic |
| pwr_good_o | output | 1 | Power good (0 = pulled low) |
| crowbar_o | output | 1 | Force low-side switch on |
| run_o | output | 1 | Modulator run enable |
| ss_restart_o | output | 1 | One-cycle soft-start restart request |

## Verification
The output flags are driven with steps held exactly FILT_LEN-1 and FILT_LEN cycles. This separates an excursion that the filter must swallow from one that must act, and it pins the edge on which the action appears. Under-voltage is applied both before and after soft-start completes, which tells arming apart from latching. Over-voltage is applied and removed, which tells the self-releasing crowbar apart from a latch. The latched states are then cleared in turn by an enable toggle, a lockout pulse and a cool-down, to show that each exit path restarts the channel with a single restart pulse.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [1:0] {
      SUP_OFF   = 2'd0,
      SUP_RUN   = 2'd1,
      SUP_LATCH = 2'd2,
      SUP_HOT   = 2'd3
   } sup_state_e;

   localparam int unsigned FLG_OVER  = 0;
   localparam int unsigned FLG_UNDER = 1;
   localparam int unsigned FLG_WIN   = 2;
   localparam int unsigned NUM_FLG   = 3;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
   parameter int unsigned FILT_LEN = 400,
   parameter bit          RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic flt_o
);
   if (FILT_LEN < 1) begin : g_bad_len
      $error("flag_filter: FILT_LEN must be at least 1");
   end

   logic q;
   assign flt_o = q;

   if (FILT_LEN == 1) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= raw_i;
      end
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(FILT_LEN);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q   <= RST_VAL;
            cnt <= '0;
         end else if (raw_i == q) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            q   <= raw_i;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      // R4: the filtered value only moves at terminal count
      assert_flip_at_terminal_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(q) |-> ($past(cnt) == LAST));
      assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST);
   end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
   import sup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chip_on_i,
   input  logic       hot_i,
   input  logic       cool_i,
   input  logic       uv_trip_i,
   input  logic       ocp_i,
   output sup_state_e state_o,
   output logic       restart_o
);
   sup_state_e state_q, state_d;
   logic       restart_q;

   always_comb begin
      state_d = state_q;
      if (!chip_on_i) begin
         state_d = SUP_OFF;
      end else begin
         unique case (state_q)
            SUP_OFF:   state_d = hot_i ? SUP_HOT : SUP_RUN;
            SUP_RUN: begin
               if (hot_i)                  state_d = SUP_HOT;
               else if (uv_trip_i || ocp_i) state_d = SUP_LATCH;
            end
            SUP_LATCH: state_d = SUP_LATCH;
            SUP_HOT:   if (cool_i && !hot_i) state_d = SUP_RUN;
            default:   state_d = SUP_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SUP_OFF;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         restart_q <= (state_d == SUP_RUN) && (state_q != SUP_RUN);
      end
   end

   assign state_o   = state_q;
   assign restart_o = restart_q;

   // R3: a latched fault holds while the chip stays on
   assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_LATCH && chip_on_i) |=> (state_q == SUP_LATCH));
   // R7: the restart request lasts a single cycle
   assert_restart_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |=> !restart_q);
   // R6: leaving the hot state needs the cool-down flag
   assert_hot_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_HOT && state_d == SUP_RUN) |-> (cool_i && !hot_i));
endmodule

// File: rtl/chan_supervisor.sv
module chan_supervisor
   import sup_pkg::*;
#(
   parameter int unsigned FILT_LEN = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic uvlo_i,
   input  logic over_i,
   input  logic under_i,
   input  logic in_win_i,
   input  logic ss_done_i,
   input  logic temp_hot_i,
   input  logic temp_cool_i,
   input  logic ocp_fault_i,
   output logic pwr_good_o,
   output logic crowbar_o,
   output logic run_o,
   output logic ss_restart_o
);
   logic [NUM_FLG-1:0] raw_flags, flt_flags;
   sup_state_e         state;
   logic               chip_on, running;

   assign raw_flags[FLG_OVER]  = over_i;
   assign raw_flags[FLG_UNDER] = under_i;
   assign raw_flags[FLG_WIN]   = in_win_i;

   for (genvar i = 0; i < NUM_FLG; i++) begin : g_filt
      flag_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b0)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw_flags[i]),
         .flt_o (flt_flags[i])
      );
   end

   assign chip_on = en_i && !uvlo_i;

   sup_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .chip_on_i (chip_on),
      .hot_i     (temp_hot_i),
      .cool_i    (temp_cool_i),
      .uv_trip_i (flt_flags[FLG_UNDER] && ss_done_i),
      .ocp_i     (ocp_fault_i),
      .state_o   (state),
      .restart_o (ss_restart_o)
   );

   assign running    = chip_on && (state == SUP_RUN);
   assign run_o      = running;
   assign pwr_good_o = running && ss_done_i && flt_flags[FLG_WIN];
   assign crowbar_o  = chip_on && (state != SUP_HOT) && flt_flags[FLG_OVER];

   // R8: disabled or locked out means safe outputs
   assert_off_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_on |-> (!run_o && !pwr_good_o && !crowbar_o));
   // R1: power good needs a running, soft-started channel
   assert_pg_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good_o |-> (run_o && ss_done_i));
   // R3: an armed under-voltage stops the run on the next edge
   assert_uv_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && flt_flags[FLG_UNDER] && ss_done_i && !temp_hot_i) |=> !run_o);
   // R6: no crowbar or power good while overheated
   assert_hot_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SUP_HOT) |-> (!crowbar_o && !pwr_good_o));
endmodule

// File: tb/chan_supervisor_test.sv
module chan_supervisor_test;
   localparam int unsigned L = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en_i = 0, uvlo_i = 0, over_i = 0, under_i = 0, in_win_i = 0;
   logic ss_done_i = 0, temp_hot_i = 0, temp_cool_i = 0, ocp_fault_i = 0;
   logic pwr_good_o, crowbar_o, run_o, ss_restart_o;
   int   checks = 0, failures = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   chan_supervisor #(.FILT_LEN(L)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
      .over_i(over_i), .under_i(under_i), .in_win_i(in_win_i),
      .ss_done_i(ss_done_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
      .ocp_fault_i(ocp_fault_i), .pwr_good_o(pwr_good_o), .crowbar_o(crowbar_o),
      .run_o(run_o), .ss_restart_o(ss_restart_o));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      cyc(3); rst_n = 1'b1; cyc(2);
      chk("R8 reset run", run_o, 1'b0);
      chk("R8 reset pg", pwr_good_o, 1'b0);
      chk("R8 reset crowbar", crowbar_o, 1'b0);
      chk("R7 reset restart", ss_restart_o, 1'b0);
   endtask

   task automatic t_startup;
      en_i = 1'b1; cyc(1);
      chk("R7 run after enable", run_o, 1'b1);
      chk("R7 restart pulse", ss_restart_o, 1'b1);
      cyc(1);
      chk("R7 restart single", ss_restart_o, 1'b0);
   endtask

   task automatic t_pgood;
      in_win_i = 1'b1; cyc(L + 2);
      chk("R1 pg low before ss_done", pwr_good_o, 1'b0);
      ss_done_i = 1'b1; cyc(1);
      chk("R1 pg high in window", pwr_good_o, 1'b1);
      in_win_i = 1'b0; cyc(L - 1);
      chk("R4 pg held short of filter", pwr_good_o, 1'b1);
      cyc(1);
      chk("R1 pg low out of window", pwr_good_o, 1'b0);
      in_win_i = 1'b1; cyc(L + 2);
      chk("R1 pg back", pwr_good_o, 1'b1);
   endtask

   task automatic t_crowbar;
      over_i = 1'b1; cyc(L - 1);
      chk("R4 crowbar not yet", crowbar_o, 1'b0);
      cyc(1);
      chk("R2 crowbar on", crowbar_o, 1'b1);
      over_i = 1'b0; cyc(L);
      chk("R2 crowbar released", crowbar_o, 1'b0);
      chk("R2 run kept", run_o, 1'b1);
   endtask

   task automatic t_glitch;
      under_i = 1'b1; cyc(L - 1); under_i = 1'b0; cyc(L + 2);
      chk("R4 short under glitch ignored", run_o, 1'b1);
   endtask

   task automatic t_uv_before_ss;
      ss_done_i = 1'b0; under_i = 1'b1; cyc(L + 2);
      chk("R3 under ignored before ss", run_o, 1'b1);
      under_i = 1'b0; cyc(L + 2);
      ss_done_i = 1'b1; cyc(1);
      chk("R3 still running", run_o, 1'b1);
   endtask

   task automatic t_uv_latch;
      under_i = 1'b1; cyc(L + 1);
      chk("R3 under latches off", run_o, 1'b0);
      chk("R3 pg low on latch", pwr_good_o, 1'b0);
      under_i = 1'b0; cyc(L + 2);
      chk("R3 latch kept", run_o, 1'b0);
      en_i = 1'b0; cyc(1); en_i = 1'b1; cyc(1);
      chk("R9 enable toggle clears", run_o, 1'b1);
      chk("R9 restart on clear", ss_restart_o, 1'b1);
   endtask

   task automatic t_ocp;
      ocp_fault_i = 1'b1; cyc(1);
      chk("R5 ocp latches", run_o, 1'b0);
      ocp_fault_i = 1'b0; cyc(3);
      chk("R5 ocp latch kept", run_o, 1'b0);
      uvlo_i = 1'b1; #1;
      chk("R8 uvlo safe pg", pwr_good_o, 1'b0);
      cyc(1); uvlo_i = 1'b0; cyc(1);
      chk("R9 uvlo cycle clears", run_o, 1'b1);
   endtask

   task automatic t_overtemp;
      temp_hot_i = 1'b1; cyc(1);
      chk("R6 hot stops run", run_o, 1'b0);
      chk("R6 hot pg low", pwr_good_o, 1'b0);
      temp_hot_i = 1'b0; cyc(3);
      chk("R6 waits for cool", run_o, 1'b0);
      temp_cool_i = 1'b1; cyc(1);
      chk("R6 resumes on cool", run_o, 1'b1);
      chk("R6 restart pulse", ss_restart_o, 1'b1);
      temp_cool_i = 1'b0; cyc(1);
   endtask

   task automatic t_disable;
      over_i = 1'b1; cyc(L + 1);
      chk("R2 crowbar before disable", crowbar_o, 1'b1);
      en_i = 1'b0; #1;
      chk("R8 disable crowbar", crowbar_o, 1'b0);
      chk("R8 disable run", run_o, 1'b0);
      chk("R8 disable pg", pwr_good_o, 1'b0);
      over_i = 1'b0; cyc(L + 2);
      en_i = 1'b1; cyc(1);
      chk("R7 restart after enable", run_o, 1'b1);
   endtask

   initial begin
      t_reset();
      t_startup();
      t_pgood();
      t_crowbar();
      t_glitch();
      t_uv_before_ss();
      t_uv_latch();
      t_ocp();
      t_overtemp();
      t_disable();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule